// File: doc/BRIEF.md
# Speculative Store Throttle Controller

This block tells a processor's memory pipeline when to stop allocating miss-tracking entries for speculative stores. Stores that are not speculative are never held back by it. It exists to prevent a livelock between processors: a speculative store that misses on one core can keep stealing the line that another core needs to complete a load-locked/store-conditional pair. The block's only output is `block_spec_store`, and the memory pipeline consumes it directly.

A two-bit mode input picks one of three behaviours. In off, the block never throttles. In full-time, it always throttles. In periodic, two timers decide. The first is an 8-bit up/down event counter that tracks branch behaviour. It rises on each mispredict pulse and falls on each retired conditional branch, and it requests throttling once it reaches a threshold. The second is a backup interval timer that throttles for a fixed window at the start of every long period.

Returning the mode to off clears the backup timer. Several processors can therefore align their backup windows by leaving and re-entering periodic mode together. There is no data stream at this block's edge. All pins are plain level or pulse controls, so no valid/ready handshake and no back-pressure rules apply.

Top module: `spec_store_throttle`

## Requirements
- R1: With the registered mode at 2'b00 (off), `block_spec_store` is 0 whatever the event pulses do.
- R2: With the registered mode at 2'b10 or 2'b11 (full-time), `block_spec_store` is 1 for every cycle that mode stays selected.
- R3: In mode 2'b01 (periodic), the backup timer counts one per clock and wraps at 2^TIMER_W (default 2,097,152). While its count is below WINDOW_LEN (default 16384), `block_spec_store` is 1. On entry to periodic from off, the count starts at 0.
- R4: In periodic mode, the event counter adds one for a `mispredict` pulse and subtracts one for a `cond_retire` pulse. If both pulses arrive in the same cycle, the counter does not change. Whenever the counter is at or above EVT_THRESH (default 128), `block_spec_store` is 1.
- R5: The event counter saturates at 255 and at 0. Extra pulses in the saturating direction leave it unchanged.
- R6: While the mode is off, both counters are cleared. While the mode is full-time, the backup timer holds its value and the event counter is cleared.
- R7: When `rst_n` is low at a rising edge, the mode register and both counters are cleared, so `block_spec_store` reads 0 after that edge.
- R8: `mode_sel` is captured on each rising edge. Counters update using the mode that was captured at the previous edge, so the edge that enters periodic does not count pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 off, 01 periodic, 10/11 full-time |
| mispredict | input | 1 | One-cycle pulse per branch mispredict |
| cond_retire | input | 1 | One-cycle pulse per retired conditional branch |
| block_spec_store | output | 1 | High while speculative store allocations must be held back |

## Verification
Every stimulus takes effect at the next rising edge: a new mode, a pulse, or a reset. `block_spec_store` is combinational from registered state, so it shows the result shortly after that same edge. The scoreboard mirrors this timing. The driver applies stimulus on the falling edge and queues the output value expected after the following rising edge. The monitor samples 1 ns after each rising edge and compares. The backup period is shortened by parameter so that window starts, wraps and restarts all fall inside the run.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_FULL     = 2'b10,
    MODE_FULL_ALT = 2'b11
  } sst_mode_e;

  // Full-time for both upper encodings.
  function automatic logic mode_is_full(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_periodic(input logic [1:0] m);
    return m == MODE_PERIODIC;
  endfunction

  function automatic logic mode_is_off(input logic [1:0] m);
    return m == MODE_OFF;
  endfunction

endpackage

// File: rtl/sst_mode_reg.sv
module sst_mode_reg
  import sst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  output logic [1:0] mode_q,
  output logic       is_off,
  output logic       is_periodic,
  output logic       is_full
);

  logic [1:0] mode_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= MODE_OFF;
    end else begin
      mode_r <= mode_sel;
    end
  end

  always_comb begin
    mode_q      = mode_r;
    is_off      = mode_is_off(mode_r);
    is_periodic = mode_is_periodic(mode_r);
    is_full     = mode_is_full(mode_r);
  end

endmodule

// File: rtl/sst_event_counter.sv
module sst_event_counter #(
  parameter int EVT_W      = 8,
  parameter int EVT_THRESH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             up_pulse,
  input  logic             down_pulse,
  output logic [EVT_W-1:0] count_q,
  output logic             over_thresh
);

  localparam logic [EVT_W-1:0] CNT_MAX = {EVT_W{1'b1}};
  localparam logic [EVT_W-1:0] CNT_MIN = '0;
  localparam logic [EVT_W-1:0] THRESH  = EVT_W'(EVT_THRESH);

  logic [EVT_W-1:0] cnt_r;
  logic [EVT_W-1:0] cnt_nxt;
  logic             at_max;
  logic             at_min;

  always_comb begin
    at_max  = cnt_r == CNT_MAX;
    at_min  = cnt_r == CNT_MIN;
    cnt_nxt = cnt_r;
    if (!enable) begin
      cnt_nxt = '0;
    end else begin
      unique case ({up_pulse, down_pulse})
        2'b10:   cnt_nxt = at_max ? cnt_r : cnt_r + 1'b1;
        2'b01:   cnt_nxt = at_min ? cnt_r : cnt_r - 1'b1;
        default: cnt_nxt = cnt_r;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_r <= '0;
    end else begin
      cnt_r <= cnt_nxt;
    end
  end

  assign count_q     = cnt_r;
  assign over_thresh = cnt_r >= THRESH;

endmodule

// File: rtl/sst_backup_timer.sv
module sst_backup_timer #(
  parameter int TIMER_W    = 21,
  parameter int WINDOW_LEN = 16384
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clear,
  output logic [TIMER_W-1:0] count_q,
  output logic               in_window
);

  localparam logic [TIMER_W-1:0] WIN_END = TIMER_W'(WINDOW_LEN);

  logic [TIMER_W-1:0] tmr_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_r <= '0;
    end else if (clear) begin
      tmr_r <= '0;
    end else if (run) begin
      tmr_r <= tmr_r + 1'b1;
    end
  end

  assign count_q   = tmr_r;
  assign in_window = tmr_r < WIN_END;

endmodule

// File: rtl/spec_store_throttle.sv
module spec_store_throttle #(
  parameter int EVT_W      = 8,
  parameter int EVT_THRESH = 128,
  parameter int TIMER_W    = 21,
  parameter int WINDOW_LEN = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       mispredict,
  input  logic       cond_retire,
  output logic       block_spec_store
);

  logic [1:0]         mode_q;
  logic               is_off;
  logic               is_periodic;
  logic               is_full;
  logic [EVT_W-1:0]   evt_count;
  logic               evt_over;
  logic [TIMER_W-1:0] bk_count;
  logic               bk_window;

  sst_mode_reg u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .mode_q      (mode_q),
    .is_off      (is_off),
    .is_periodic (is_periodic),
    .is_full     (is_full)
  );

  sst_event_counter #(
    .EVT_W      (EVT_W),
    .EVT_THRESH (EVT_THRESH)
  ) u_evt (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (is_periodic),
    .up_pulse    (mispredict),
    .down_pulse  (cond_retire),
    .count_q     (evt_count),
    .over_thresh (evt_over)
  );

  sst_backup_timer #(
    .TIMER_W    (TIMER_W),
    .WINDOW_LEN (WINDOW_LEN)
  ) u_bk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (is_periodic),
    .clear     (is_off),
    .count_q   (bk_count),
    .in_window (bk_window)
  );

  assign block_spec_store = is_full | (is_periodic & (evt_over | bk_window));

endmodule

// File: rtl/spec_store_throttle_chk.sv
module spec_store_throttle_chk #(
  parameter int EVT_W      = 8,
  parameter int EVT_THRESH = 128,
  parameter int TIMER_W    = 21,
  parameter int WINDOW_LEN = 16384
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode_sel,
  input logic               mispredict,
  input logic               cond_retire,
  input logic               block_spec_store,
  input logic [1:0]         mode_q,
  input logic [EVT_W-1:0]   evt_count,
  input logic [TIMER_W-1:0] bk_count
);

  // R7
  reset_clears_chk: assert property (@(posedge clk)
    !rst_n |=> (!block_spec_store && evt_count == '0 && bk_count == '0));

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b00 |-> !block_spec_store);

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> block_spec_store);

  // R8
  mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> mode_q == $past(mode_sel));

  // R5
  evt_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && evt_count == {EVT_W{1'b1}} && mispredict && !cond_retire)
      |=> evt_count == {EVT_W{1'b1}});

  // R5
  evt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && evt_count == '0 && cond_retire && !mispredict)
      |=> evt_count == '0);

  // R4
  evt_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && mispredict && cond_retire) |=> $stable(evt_count));

  // R4
  evt_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && evt_count >= EVT_W'(EVT_THRESH)) |-> block_spec_store);

  // R6
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b00 |=> (bk_count == '0 && evt_count == '0));

  // R3
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b01 && bk_count < TIMER_W'(WINDOW_LEN)) |-> block_spec_store);

endmodule

bind spec_store_throttle spec_store_throttle_chk #(
  .EVT_W      (EVT_W),
  .EVT_THRESH (EVT_THRESH),
  .TIMER_W    (TIMER_W),
  .WINDOW_LEN (WINDOW_LEN)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .mode_sel         (mode_sel),
  .mispredict       (mispredict),
  .cond_retire      (cond_retire),
  .block_spec_store (block_spec_store),
  .mode_q           (mode_q),
  .evt_count        (evt_count),
  .bk_count         (bk_count)
);

// File: tb/spec_store_throttle_bench.sv
`timescale 1ns/1ps
module spec_store_throttle_bench;

  localparam int TB_TIMER_W = 9;
  localparam int TB_PERIOD  = 1 << TB_TIMER_W;
  localparam int TB_WINDOW  = 32;
  localparam int TB_THRESH  = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       mispredict = 1'b0;
  logic       cond_retire = 1'b0;
  logic       block_spec_store;

  always #2.5 clk = ~clk;

  spec_store_throttle #(
    .EVT_W      (8),
    .EVT_THRESH (TB_THRESH),
    .TIMER_W    (TB_TIMER_W),
    .WINDOW_LEN (TB_WINDOW)
  ) u_spec_store_throttle (
    .clk              (clk),
    .rst_n            (rst_n),
    .mode_sel         (mode_sel),
    .mispredict       (mispredict),
    .cond_retire      (cond_retire),
    .block_spec_store (block_spec_store)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  // Reference model state, built from the requirements.
  int m_mode = 0;
  int m_evt  = 0;
  int m_bk   = 0;

  task automatic step(input logic r, input logic [1:0] m, input logic mp,
                      input logic cr, input string tag);
    bit e;
    @(negedge clk);
    rst_n = r; mode_sel = m; mispredict = mp; cond_retire = cr;
    if (!r) begin
      m_mode = 0; m_evt = 0; m_bk = 0;
    end else begin
      if (m_mode == 1) begin
        if (mp && !cr && m_evt < 255) m_evt++;
        else if (cr && !mp && m_evt > 0) m_evt--;
        m_bk = (m_bk + 1) % TB_PERIOD;
      end else begin
        m_evt = 0;
        if (m_mode == 0) m_bk = 0;
      end
      m_mode = int'(m);
    end
    e = (m_mode >= 2) || (m_mode == 1 && (m_evt >= TB_THRESH || m_bk < TB_WINDOW));
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic run(input int n, input logic r, input logic [1:0] m,
                     input logic mp, input logic cr, input string tag);
    for (int i = 0; i < n; i++) step(r, m, mp, cr, tag);
  endtask

  // Monitor: compares each result 1 ns after the edge that produces it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_checks++;
        if (block_spec_store !== e) begin
          n_fail++;
          $display("FAIL %s: block_spec_store got %b expected %b at %0t",
                   t, block_spec_store, e, $time);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    run(3, 1'b0, 2'b01, 1'b1, 1'b0, "R7");
    // R1 off ignores pulses
    run(4, 1'b1, 2'b00, 1'b1, 1'b0, "R1");
    run(4, 1'b1, 2'b00, 1'b0, 1'b1, "R1");
    // R2 full-time, both encodings
    run(10, 1'b1, 2'b10, 1'b1, 1'b0, "R2");
    run(6, 1'b1, 2'b11, 1'b0, 1'b1, "R2");
    // R6 back to off clears; R8 one-edge latency
    run(3, 1'b1, 2'b00, 1'b0, 1'b0, "R8");
    // R3 backup window, wrap and second window
    run(TB_PERIOD + TB_WINDOW + 20, 1'b1, 2'b01, 1'b0, 1'b0, "R3");
    run(2, 1'b1, 2'b00, 1'b0, 1'b0, "R6");
    // R8 entry edge ignores pulses; then idle past window
    step(1'b1, 2'b01, 1'b1, 1'b0, "R8");
    run(TB_WINDOW + 5, 1'b1, 2'b01, 1'b0, 1'b0, "R3");
    // R5 floor at zero
    run(10, 1'b1, 2'b01, 1'b0, 1'b1, "R5");
    // R4 climb to just below threshold
    run(127, 1'b1, 2'b01, 1'b1, 1'b0, "R4");
    run(5, 1'b1, 2'b01, 1'b1, 1'b1, "R4");
    step(1'b1, 2'b01, 1'b1, 1'b0, "R4");
    // R5 ceiling at 255
    run(200, 1'b1, 2'b01, 1'b1, 1'b0, "R5");
    run(127, 1'b1, 2'b01, 1'b0, 1'b1, "R5");
    run(3, 1'b1, 2'b01, 1'b0, 1'b1, "R4");
    // R6 full-time holds timer, event counter cleared
    run(20, 1'b1, 2'b10, 1'b0, 1'b0, "R6");
    run(TB_PERIOD, 1'b1, 2'b01, 1'b0, 1'b0, "R6");
    // R6 off then periodic restarts the window
    step(1'b1, 2'b00, 1'b0, 1'b0, "R6");
    run(TB_WINDOW + 4, 1'b1, 2'b01, 1'b0, 1'b0, "R6");
    // R7 reset in the middle of full-time
    run(3, 1'b1, 2'b10, 1'b0, 1'b0, "R2");
    step(1'b0, 2'b10, 1'b0, 1'b0, "R7");
    run(3, 1'b1, 2'b00, 1'b0, 1'b0, "R7");
    @(posedge clk);
    #2;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule